// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps the system time of day as a 48-bit seconds count and a 30-bit nanoseconds count. On every enabled clock it adds a programmable period. The period has a 16-bit whole-nanosecond part and a 48-bit fraction, in units of 2^-48 ns. A 48-bit fraction accumulator carries into the nanoseconds, so a clock whose period is not a whole number of nanoseconds runs without long-term drift. When the nanoseconds reach one second, they wrap into the seconds, and a single-cycle pulse marks each new second.

Software can replace the time at any moment. It can also latch a signed seconds and nanoseconds offset. The offset is added only on the time output that feeds downstream timers. The live count and the snapshot copy both show the time without the offset. A snapshot strobe captures the live time into holding registers for readback. A rising edge on an external pulse-per-second input does the same when that input is enabled.

Top module: `tod_counter`

## Requirements
- R1: After reset the seconds, nanoseconds, fraction, offsets and snapshot registers are zero, `pps_pulse` is low and the period is `PERIOD_INIT` (default 5 ns, i.e. 64'h0005_0000_0000_0000).
- R2: While `en` is high, each clock adds the period. Period bits [63:48] are whole nanoseconds and bits [47:0] are a fraction in units of 2^-48 ns. A carry out of the fraction accumulator adds 1 ns.
- R3: A write with `period_lo_we` stores `period_wdata` as the staged period bits [31:0] and does not change the count. A write with `period_hi_we` commits {`period_wdata`, staged low word} as the new period. If both strobes are high, the commit wins and the staged word is kept.
- R4: When the nanoseconds plus the increment reach 1,000,000,000 or more, 10^9 is subtracted and the seconds advance by one.
- R5: `pps_pulse` is high for exactly the one cycle in which a newly incremented seconds value first appears on the outputs.
- R6: While `en` is low and no load is requested, the time does not change.
- R7: `ld_time` replaces the seconds and nanoseconds with `ld_sec`/`ld_ns` and clears the fraction. It takes priority over counting and raises no pulse.
- R8: `ld_ofs` latches `ofs_sec` (48-bit two's complement) and `ofs_ns` (30-bit two's complement, magnitude below 10^9). `out_sec`/`out_ns` give the time plus the offset, with the nanoseconds normalised into [0, 10^9) through a carry or a borrow into the seconds.
- R9: `snap` copies the live time, without the offset, into `snap_sec`/`snap_ns` on the next clock.
- R10: With `pps_in_en` high, a rising edge of `pps_in` captures a snapshot as in R9. With `pps_in_en` low, the edge leaves the snapshot registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counting enable |
| period_lo_we | input | 1 | Stage low period word |
| period_hi_we | input | 1 | Commit high period word |
| period_wdata | input | 32 | Period word data |
| ld_time | input | 1 | Load time strobe |
| ld_sec | input | 48 | Seconds to load |
| ld_ns | input | 30 | Nanoseconds to load (below 10^9) |
| ld_ofs | input | 1 | Latch offset strobe |
| ofs_sec | input | 48 | Signed seconds offset |
| ofs_ns | input | 30 | Signed nanoseconds offset |
| snap | input | 1 | Snapshot strobe |
| pps_in | input | 1 | External pulse-per-second |
| pps_in_en | input | 1 | Allow external pulse to snapshot |
| out_sec | output | 48 | Seconds with offset applied |
| out_ns | output | 30 | Nanoseconds with offset applied |
| snap_sec | output | 48 | Captured seconds |
| snap_ns | output | 30 | Captured nanoseconds |
| pps_pulse | output | 1 | One-cycle new-second pulse |

## Verification
The hardest situations to reach are the fraction carry and the second wrap, because at 5 ns per clock reaching them from zero would take hundreds of millions of cycles. The bench loads a time a few nanoseconds short of a second boundary while counting is halted. It then opens `en` for an exact number of edges, so the wrap and the pulse land on a known cycle. For the fraction, it commits a 2.5 ns period and checks after an odd and then an even number of steps, where the half-nanosecond carry must appear. Offset borrow is reached by pairing a small live nanosecond value with a negative offset.

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int SEC_W = 48,
  parameter int NS_W = 30,
  parameter int FRAC_W = 48,
  parameter int unsigned NS_WRAP = 1_000_000_000,
  parameter logic [63:0] PERIOD_INIT = 64'h0005_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              period_lo_we,
  input  logic              period_hi_we,
  input  logic [31:0]       period_wdata,
  input  logic              ld_time,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [NS_W-1:0]   ld_ns,
  input  logic              ld_ofs,
  input  logic [SEC_W-1:0]  ofs_sec,
  input  logic [NS_W-1:0]   ofs_ns,
  input  logic              snap,
  input  logic              pps_in,
  input  logic              pps_in_en,
  output logic [SEC_W-1:0]  out_sec,
  output logic [NS_W-1:0]   out_ns,
  output logic [SEC_W-1:0]  snap_sec,
  output logic [NS_W-1:0]   snap_ns,
  output logic              pps_pulse
);
  localparam int PER_W = 64;
  localparam int SUM_W = NS_W + 2;
  localparam logic [SUM_W-1:0] WRAP_V = SUM_W'(NS_WRAP);

  logic [SEC_W-1:0]  sec_q, off_sec_q;
  logic [NS_W-1:0]   ns_q, off_ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [PER_W-1:0]  per_q;
  logic [31:0]       per_lo_q;
  logic              ext_d;

  logic [FRAC_W:0]   frac_sum;
  logic [SUM_W-1:0]  ns_sum, ns_ofs, ns_fix;
  logic              wrap, borrow, carry, ext_snap;

  assign frac_sum = {1'b0, frac_q} + {1'b0, per_q[FRAC_W-1:0]};
  assign ns_sum   = SUM_W'(ns_q) + SUM_W'(per_q[PER_W-1:FRAC_W]) + SUM_W'(frac_sum[FRAC_W]);
  assign wrap     = ns_sum >= WRAP_V;

  assign ns_ofs = SUM_W'(ns_q) + {{2{off_ns_q[NS_W-1]}}, off_ns_q};
  assign borrow = ns_ofs[SUM_W-1];
  assign carry  = !borrow && (ns_ofs >= WRAP_V);
  assign ns_fix = borrow ? ns_ofs + WRAP_V : (carry ? ns_ofs - WRAP_V : ns_ofs);
  assign out_ns = ns_fix[NS_W-1:0];
  assign out_sec = sec_q + off_sec_q + (borrow ? {SEC_W{1'b1}} : SEC_W'(carry));

  assign ext_snap = pps_in_en && pps_in && !ext_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q     <= '0;
      ns_q      <= '0;
      frac_q    <= '0;
      per_q     <= PERIOD_INIT;
      per_lo_q  <= PERIOD_INIT[31:0];
      off_sec_q <= '0;
      off_ns_q  <= '0;
      snap_sec  <= '0;
      snap_ns   <= '0;
      pps_pulse <= 1'b0;
      ext_d     <= 1'b0;
    end else begin
      ext_d     <= pps_in;
      pps_pulse <= 1'b0;
      if (period_hi_we)
        per_q <= {period_wdata, per_lo_q};
      else if (period_lo_we)
        per_lo_q <= period_wdata;
      if (ld_time) begin
        sec_q  <= ld_sec;
        ns_q   <= ld_ns;
        frac_q <= '0;
      end else if (en) begin
        frac_q    <= frac_sum[FRAC_W-1:0];
        ns_q      <= wrap ? NS_W'(ns_sum - WRAP_V) : ns_sum[NS_W-1:0];
        sec_q     <= sec_q + SEC_W'(wrap);
        pps_pulse <= wrap;
      end
      if (ld_ofs) begin
        off_sec_q <= ofs_sec;
        off_ns_q  <= ofs_ns;
      end
      if (snap || ext_snap) begin
        snap_sec <= sec_q;
        snap_ns  <= ns_q;
      end
    end
  end
endmodule

module tod_counter_chk #(
  parameter int SEC_W = 48,
  parameter int NS_W = 30,
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             ld_time,
  input logic [SEC_W-1:0] ld_sec,
  input logic [NS_W-1:0]  ld_ns,
  input logic             period_lo_we,
  input logic             period_hi_we,
  input logic             snap,
  input logic [SEC_W-1:0] sec_q,
  input logic [NS_W-1:0]  ns_q,
  input logic [63:0]      per_q,
  input logic [SEC_W-1:0] snap_sec,
  input logic [NS_W-1:0]  snap_ns,
  input logic             pps_pulse
);
  // R4
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ns_q) < NS_WRAP);
  // R5
  pps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_pulse |-> sec_q == $past(sec_q) + SEC_W'(1));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld_time) |=> ($stable(sec_q) && $stable(ns_q)));
  // R3
  lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_lo_we && !period_hi_we) |=> $stable(per_q));
  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_time |=> (sec_q == $past(ld_sec) && ns_q == $past(ld_ns) && !pps_pulse));
  // R9
  snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (snap_sec == $past(sec_q) && snap_ns == $past(ns_q)));
endmodule

bind tod_counter tod_counter_chk #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_WRAP(NS_WRAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ld_time(ld_time), .ld_sec(ld_sec), .ld_ns(ld_ns),
  .period_lo_we(period_lo_we), .period_hi_we(period_hi_we), .snap(snap),
  .sec_q(sec_q), .ns_q(ns_q), .per_q(per_q), .snap_sec(snap_sec), .snap_ns(snap_ns),
  .pps_pulse(pps_pulse)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        period_lo_we = 1'b0, period_hi_we = 1'b0;
  logic [31:0] period_wdata = '0;
  logic        ld_time = 1'b0, ld_ofs = 1'b0, snap = 1'b0;
  logic [47:0] ld_sec = '0, ofs_sec = '0;
  logic [29:0] ld_ns = '0, ofs_ns = '0;
  logic        pps_in = 1'b0, pps_in_en = 1'b0;
  logic [47:0] out_sec, snap_sec;
  logic [29:0] out_ns, snap_ns;
  logic        pps_pulse;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tod_counter u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period_lo_we(period_lo_we), .period_hi_we(period_hi_we),
    .period_wdata(period_wdata), .ld_time(ld_time), .ld_sec(ld_sec), .ld_ns(ld_ns),
    .ld_ofs(ld_ofs), .ofs_sec(ofs_sec), .ofs_ns(ofs_ns), .snap(snap), .pps_in(pps_in),
    .pps_in_en(pps_in_en), .out_sec(out_sec), .out_ns(out_ns), .snap_sec(snap_sec),
    .snap_ns(snap_ns), .pps_pulse(pps_pulse)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_time(input string req, input longint s, input longint n);
    check(out_sec == 48'(s), req, longint'(out_sec), s);
    check(out_ns == 30'(n), req, longint'(out_ns), n);
  endtask

  task automatic load(input longint s, input longint n);
    @(negedge clk); ld_time = 1'b1; ld_sec = 48'(s); ld_ns = 30'(n);
    @(negedge clk); ld_time = 1'b0;
  endtask

  task automatic set_ofs(input longint s, input longint n);
    @(negedge clk); ld_ofs = 1'b1; ofs_sec = 48'(s); ofs_ns = 30'(n);
    @(negedge clk); ld_ofs = 1'b0;
  endtask

  task automatic wr_period(input bit hi, input logic [31:0] d);
    @(negedge clk); period_lo_we = !hi; period_hi_we = hi; period_wdata = d;
    @(negedge clk); period_lo_we = 1'b0; period_hi_we = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk); en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); en = 1'b0;
  endtask

  task automatic do_snap();
    @(negedge clk); snap = 1'b1;
    @(negedge clk); snap = 1'b0;
  endtask

  task automatic t_reset();
    chk_time("R1", 0, 0);
    check(snap_sec == 0 && snap_ns == 0, "R1", longint'(snap_ns), 0);
    check(pps_pulse == 1'b0, "R1", longint'(pps_pulse), 0);
    run(3);
    chk_time("R1", 0, 15);
  endtask

  task automatic t_count();
    load(10, 100);
    run(7);
    chk_time("R2", 10, 135);
    do_snap();
    check(snap_sec == 48'd10 && snap_ns == 30'd135, "R9", longint'(snap_ns), 135);
  endtask

  task automatic t_hold();
    load(3, 40);
    repeat (6) @(negedge clk);
    chk_time("R6", 3, 40);
  endtask

  task automatic t_frac();
    wr_period(1'b0, 32'h0);
    wr_period(1'b1, 32'h0002_8000);
    load(0, 0);
    run(3);
    chk_time("R2", 0, 7);
    run(1);
    chk_time("R2", 0, 10);
    wr_period(1'b0, 32'hFFFF_FFFF);
    load(0, 0);
    run(2);
    chk_time("R3", 0, 5);
    wr_period(1'b0, 32'h0);
    wr_period(1'b1, 32'h0005_0000);
    load(0, 0);
    run(2);
    chk_time("R3", 0, 10);
  endtask

  task automatic t_wrap();
    load(5, 999_999_998);
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
    chk_time("R4", 6, 3);
    check(pps_pulse == 1'b1, "R5", longint'(pps_pulse), 1);
    @(negedge clk);
    check(pps_pulse == 1'b0, "R5", longint'(pps_pulse), 0);
    run(2);
    check(pps_pulse == 1'b0, "R5", longint'(pps_pulse), 0);
    chk_time("R4", 6, 13);
  endtask

  task automatic t_load_prio();
    load(1, 0);
    @(negedge clk); en = 1'b1; ld_time = 1'b1; ld_sec = 48'd77; ld_ns = 30'd999_999_999;
    @(negedge clk); ld_time = 1'b0; en = 1'b0;
    chk_time("R7", 77, 999_999_999);
    check(pps_pulse == 1'b0, "R7", longint'(pps_pulse), 0);
  endtask

  task automatic t_offset();
    load(100, 999_999_000);
    set_ofs(2, 5000);
    chk_time("R8", 103, 4000);
    do_snap();
    check(snap_sec == 48'd100 && snap_ns == 30'd999_999_000, "R8", longint'(snap_ns), 999_999_000);
    load(100, 1000);
    set_ofs(-1, -2000);
    chk_time("R8", 98, 999_999_000);
    load(100, 1000);
    set_ofs(0, 500);
    chk_time("R8", 100, 1500);
    set_ofs(0, 0);
  endtask

  task automatic t_ext_pps();
    load(42, 77);
    @(negedge clk); pps_in_en = 1'b1; pps_in = 1'b1;
    @(negedge clk); pps_in = 1'b0;
    check(snap_sec == 48'd42 && snap_ns == 30'd77, "R10", longint'(snap_ns), 77);
    load(43, 88);
    @(negedge clk); pps_in_en = 1'b0; pps_in = 1'b1;
    @(negedge clk); pps_in = 1'b0;
    @(negedge clk);
    check(snap_sec == 48'd42 && snap_ns == 30'd77, "R10", longint'(snap_ns), 77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_hold();
    t_frac();
    t_wrap();
    t_load_prio();
    t_offset();
    t_ext_pps();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule